// File: doc/BRIEF.md
# Translation-Cache Invalidation Command Sequencer

This block sits between an IOMMU command queue and a tagged address-translation cache. It takes one 128-bit invalidation command, split into a low and a high doubleword, and decodes it in one of two forms. The virtual-address form targets either single-stage or nested entries. The guest-physical form targets entries that involve guest translation. The block turns each command into one or two invalidation requests. Every request names the kind of cache entry it applies to, which of the GSCID, PSCID and page-address fields must match, the ID values, and a page-aligned address. The cache uses the request to drop matching entries.

Cache entries carry a 2-bit translation-kind tag: 0 bypass, 1 single-stage, 2 guest-stage-only, 3 nested. The tag stops a virtual-address invalidation without a guest ID from touching nested entries that happen to share a PSCID. A guest-physical command must reach both guest-stage-only and nested entries, so it is issued twice, back to back, with only the tag changed.

Both sides use valid/ready. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no request is pending and no error is being reported. A request is offered with `req_valid` and completes on an edge where `req_ready` is also high. While `req_ready` is low, every request field stays unchanged. Illegal commands produce no request and a single-cycle `cmd_err` pulse.

Top module: `inval_cmd_seq`

## Requirements
- R1: `cmd_ready` is high only when no request is pending and no error is being reported. A command taken on an edge shows up as `req_valid` high in the next cycle.
- R2: While `req_valid` is high and `req_ready` is low, `req_valid` and every request field hold their values into the next cycle.
- R3: `req_addr` equals the high doubleword shifted left by 2, with the low 12 bits (the page offset) cleared.
- R4: A guest-physical command (function 1) with PSCV (low bit 32) set issues no request. It raises `cmd_err` for exactly one cycle, and `cmd_ready` is high again in the cycle after that pulse.
- R5: A guest-physical command never matches PSCID. With GV (low bit 33) clear, it matches no field. With GV set, it matches GSCID, and it also matches the address when AV (low bit 10) is set.
- R6: A guest-physical command issues two requests with identical fields. The first carries tag 2 (guest-stage-only). The second carries tag 3 (nested) and is offered only after the first has been accepted.
- R7: A virtual-address command (function 0) with GV set issues one request with tag 3. That request always matches GSCID, matches PSCID when PSCV is set, and matches the address when AV is set.
- R8: A virtual-address command with GV clear issues one request with tag 1. That request never matches GSCID, matches PSCID when PSCV is set, and matches the address when AV is set.
- R9: A command whose opcode (low bits 6:0) differs from 7'h01, or whose function code (low bits 9:7) is neither 0 nor 1, is handled like an illegal command: no request, and a one-cycle `cmd_err`.
- R10: `req_gscid` carries low bits 59:44 and `req_pscid` carries low bits 31:12 of the accepted command.
- R11: After reset, `cmd_ready` is high and `req_valid` and `cmd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_lo | input | 64 | Command low doubleword: opcode, function, flags, IDs |
| cmd_hi | input | 64 | Command high doubleword: address field |
| req_valid | output | 1 | Invalidation request offered |
| req_ready | input | 1 | Cache accepts the request |
| req_tag | output | 2 | Target translation kind (1 single, 2 guest-only, 3 nested) |
| req_match_gscid | output | 1 | Entry GSCID must equal `req_gscid` |
| req_match_pscid | output | 1 | Entry PSCID must equal `req_pscid` |
| req_match_addr | output | 1 | Entry page must equal `req_addr` |
| req_gscid | output | 16 | Guest soft-context ID |
| req_pscid | output | 20 | Process soft-context ID |
| req_addr | output | 64 | Page-aligned invalidation address |
| cmd_err | output | 1 | One-cycle illegal-command pulse |

## Verification
On every cycle, the assertions check four properties of the request and error handshakes. A stalled request keeps its valid and its contents. The error pulse lasts one cycle and never overlaps a request. The sequencer never offers a request while it is ready for a command. They also check two properties of the passes. A guest-stage-only pass is always followed by a nested pass. No guest-stage pass and no single-stage request asks for a match it must not have. Only the bench scenarios can show that each combination of function, GV, AV and PSCV yields the right tag and match enables, that the ID fields and address are taken from the correct bits, and that illegal opcodes and functions are refused.

// File: rtl/inval_pkg.sv
package inval_pkg;

  typedef enum logic [1:0] {
    TAG_BYPASS = 2'd0,
    TAG_SINGLE = 2'd1,
    TAG_GUEST  = 2'd2,
    TAG_NESTED = 2'd3
  } xlat_tag_e;

  typedef struct packed {
    xlat_tag_e tag;
    logic      m_gscid;
    logic      m_pscid;
    logic      m_addr;
  } match_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS1 = 2'd1,
    ST_PASS2 = 2'd2,
    ST_FAULT = 2'd3
  } seq_state_e;

endpackage

// File: rtl/inval_decode.sv
module inval_decode
  import inval_pkg::*;
#(
  parameter int            CMD_W     = 64,
  parameter int            ADDR_W    = 64,
  parameter int            PAGE_BITS = 12,
  parameter int            GSCID_W   = 16,
  parameter int            PSCID_W   = 20,
  parameter logic [6:0]    OPCODE    = 7'h01
) (
  input  logic [CMD_W-1:0]   lo,
  input  logic [CMD_W-1:0]   hi,
  output logic               legal,
  output logic               two_pass,
  output match_t             first,
  output logic [GSCID_W-1:0] gscid,
  output logic [PSCID_W-1:0] pscid,
  output logic [ADDR_W-1:0]  addr
);

  localparam int GV_BIT    = 33;
  localparam int PSCV_BIT  = 32;
  localparam int AV_BIT    = 10;
  localparam int PSCID_LSB = 12;
  localparam int GSCID_LSB = 44;
  localparam int FN_LSB    = 7;
  localparam logic [2:0] FN_VMA  = 3'd0;
  localparam logic [2:0] FN_GVMA = 3'd1;
  localparam logic [ADDR_W-1:0] PAGE_MASK =
    ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

  logic       gv, av, pscv, opc_ok;
  logic [2:0] fn;

  assign gv     = lo[GV_BIT];
  assign av     = lo[AV_BIT];
  assign pscv   = lo[PSCV_BIT];
  assign fn     = lo[FN_LSB +: 3];
  assign opc_ok = (lo[6:0] == OPCODE);
  assign gscid  = lo[GSCID_LSB +: GSCID_W];
  assign pscid  = lo[PSCID_LSB +: PSCID_W];
  assign addr   = (hi[ADDR_W-1:0] << 2) & PAGE_MASK;

  logic unused_bits;
  assign unused_bits = ^{lo[CMD_W-1:GSCID_LSB+GSCID_W], lo[GSCID_LSB-1:GV_BIT+1], lo[11]};

  always_comb begin
    legal    = 1'b0;
    two_pass = 1'b0;
    first    = '{tag: TAG_BYPASS, m_gscid: 1'b0, m_pscid: 1'b0, m_addr: 1'b0};
    if (opc_ok && fn == FN_GVMA) begin
      legal         = !pscv;
      two_pass      = 1'b1;
      first.tag     = TAG_GUEST;
      first.m_gscid = gv;
      first.m_addr  = gv & av;
    end else if (opc_ok && fn == FN_VMA) begin
      legal         = 1'b1;
      first.tag     = gv ? TAG_NESTED : TAG_SINGLE;
      first.m_gscid = gv;
      first.m_pscid = pscv;
      first.m_addr  = av;
    end
  end

endmodule

// File: rtl/inval_issue.sv
module inval_issue
  import inval_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int GSCID_W = 16,
  parameter int PSCID_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               dec_legal,
  input  logic               dec_two,
  input  match_t             dec_match,
  input  logic [GSCID_W-1:0] dec_gscid,
  input  logic [PSCID_W-1:0] dec_pscid,
  input  logic [ADDR_W-1:0]  dec_addr,
  output logic               req_valid,
  input  logic               req_ready,
  output match_t             req_match,
  output logic [GSCID_W-1:0] req_gscid,
  output logic [PSCID_W-1:0] req_pscid,
  output logic [ADDR_W-1:0]  req_addr,
  output logic               cmd_err
);

  seq_state_e         state;
  match_t             match_q;
  logic               two_q;
  logic [GSCID_W-1:0] gscid_q;
  logic [PSCID_W-1:0] pscid_q;
  logic [ADDR_W-1:0]  addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      match_q <= '0;
      two_q   <= 1'b0;
      gscid_q <= '0;
      pscid_q <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          if (dec_legal) begin
            state   <= ST_PASS1;
            match_q <= dec_match;
            two_q   <= dec_two;
            gscid_q <= dec_gscid;
            pscid_q <= dec_pscid;
            addr_q  <= dec_addr;
          end else begin
            state <= ST_FAULT;
          end
        end
        ST_PASS1: if (req_ready) begin
          if (two_q) begin
            state       <= ST_PASS2;
            match_q.tag <= TAG_NESTED;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_PASS2: if (req_ready) state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign req_valid = (state == ST_PASS1) || (state == ST_PASS2);
  assign cmd_err   = (state == ST_FAULT);
  assign req_match = match_q;
  assign req_gscid = gscid_q;
  assign req_pscid = pscid_q;
  assign req_addr  = addr_q;

  // R2
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_match) &&
      $stable(req_gscid) && $stable(req_pscid) && $stable(req_addr)));

  // R4
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> (!cmd_err && cmd_ready));

  // R4
  err_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !req_valid);

  // R1
  ready_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!req_valid && !cmd_err));

  // R6
  guest_then_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_match.tag == TAG_GUEST) |=>
      (req_valid && req_match.tag == TAG_NESTED));

  // R5
  guest_no_pscid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_match.tag == TAG_GUEST) |-> !req_match.m_pscid);

  // R8
  single_no_gscid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_match.tag == TAG_SINGLE) |-> !req_match.m_gscid);

endmodule

// File: rtl/inval_cmd_seq.sv
module inval_cmd_seq
  import inval_pkg::*;
#(
  parameter int         CMD_W     = 64,
  parameter int         ADDR_W    = 64,
  parameter int         PAGE_BITS = 12,
  parameter int         GSCID_W   = 16,
  parameter int         PSCID_W   = 20,
  parameter logic [6:0] OPCODE    = 7'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [CMD_W-1:0]   cmd_lo,
  input  logic [CMD_W-1:0]   cmd_hi,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [1:0]         req_tag,
  output logic               req_match_gscid,
  output logic               req_match_pscid,
  output logic               req_match_addr,
  output logic [GSCID_W-1:0] req_gscid,
  output logic [PSCID_W-1:0] req_pscid,
  output logic [ADDR_W-1:0]  req_addr,
  output logic               cmd_err
);

  logic               d_legal, d_two;
  match_t             d_match, r_match;
  logic [GSCID_W-1:0] d_gscid;
  logic [PSCID_W-1:0] d_pscid;
  logic [ADDR_W-1:0]  d_addr;

  inval_decode #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
    .GSCID_W(GSCID_W), .PSCID_W(PSCID_W), .OPCODE(OPCODE)
  ) u_dec (
    .lo(cmd_lo), .hi(cmd_hi), .legal(d_legal), .two_pass(d_two),
    .first(d_match), .gscid(d_gscid), .pscid(d_pscid), .addr(d_addr)
  );

  inval_issue #(
    .ADDR_W(ADDR_W), .GSCID_W(GSCID_W), .PSCID_W(PSCID_W)
  ) u_iss (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .dec_legal(d_legal), .dec_two(d_two), .dec_match(d_match),
    .dec_gscid(d_gscid), .dec_pscid(d_pscid), .dec_addr(d_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_match(r_match),
    .req_gscid(req_gscid), .req_pscid(req_pscid), .req_addr(req_addr),
    .cmd_err(cmd_err)
  );

  assign req_tag         = r_match.tag;
  assign req_match_gscid = r_match.m_gscid;
  assign req_match_pscid = r_match.m_pscid;
  assign req_match_addr  = r_match.m_addr;

endmodule

// File: tb/inval_cmd_seq_test.sv
module inval_cmd_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [63:0] cmd_lo = '0, cmd_hi = '0;
  logic        req_ready = 1'b0;
  logic        cmd_ready, req_valid, req_match_gscid, req_match_pscid, req_match_addr, cmd_err;
  logic [1:0]  req_tag;
  logic [15:0] req_gscid;
  logic [19:0] req_pscid;
  logic [63:0] req_addr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  inval_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .req_match_gscid(req_match_gscid), .req_match_pscid(req_match_pscid),
    .req_match_addr(req_match_addr), .req_gscid(req_gscid), .req_pscid(req_pscid),
    .req_addr(req_addr), .cmd_err(cmd_err)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_lo(input logic [6:0] opc, input logic [2:0] fn,
      input bit gv, input bit av, input bit pscv, input logic [15:0] g, input logic [19:0] p);
    logic [63:0] v = '0;
    v[6:0] = opc; v[9:7] = fn; v[10] = av; v[31:12] = p; v[32] = pscv; v[33] = gv; v[59:44] = g;
    return v;
  endfunction

  task automatic send(input logic [63:0] lo, input logic [63:0] hi);
    @(negedge clk);
    cmd_lo = lo; cmd_hi = hi; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_lo = '0; cmd_hi = '0;
  endtask

  task automatic accept();
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic expect_req(input string rq, input logic [1:0] tag, input bit mg, input bit mp,
      input bit ma, input logic [15:0] g, input logic [19:0] p, input logic [63:0] a);
    logic [63:0] act = {58'd0, req_valid, req_tag, req_match_gscid, req_match_pscid, req_match_addr};
    logic [63:0] exp = {58'd0, 1'b1, tag, mg, mp, ma};
    chk(act == exp, {rq, " valid/tag/match"}, act, exp);
    chk(req_gscid == g && req_pscid == p, {rq, " R10 ids"}, {req_gscid, 4'd0, req_pscid}, {g, 4'd0, p});
    chk(req_addr == a, {rq, " R3 addr"}, req_addr, a);
    chk(!cmd_ready, {rq, " R1 busy"}, cmd_ready, 0);
  endtask

  task automatic expect_idle(input string rq);
    chk(cmd_ready && !req_valid && !cmd_err, rq, {cmd_ready, req_valid, cmd_err}, 3'b100);
  endtask

  function automatic logic [63:0] page(input logic [63:0] hi);
    return (hi << 2) & ~64'hFFF;
  endfunction

  task automatic t_reset();
    expect_idle("R11 reset state");
  endtask

  task automatic t_vma_nested_full();
    logic [63:0] hi = 64'h0123_4567_89AB_CDEF;
    send(mk_lo(7'h01, 3'd0, 1, 1, 1, 16'hBEEF, 20'hABCDE), hi);
    expect_req("R7 vma gv av pscv", 2'd3, 1, 1, 1, 16'hBEEF, 20'hABCDE, page(hi));
    accept();
    expect_idle("R1 idle after vma");
  endtask

  task automatic t_vma_nested_min();
    logic [63:0] hi = 64'hFFFF_FFFF_FFFF_FFFF;
    send(mk_lo(7'h01, 3'd0, 1, 0, 0, 16'h0001, 20'h00002), hi);
    expect_req("R7 vma gv only", 2'd3, 1, 0, 0, 16'h0001, 20'h00002, page(hi));
    accept();
    expect_idle("R1 idle");
  endtask

  task automatic t_vma_single_all();
    send(mk_lo(7'h01, 3'd0, 0, 0, 0, 16'h1234, 20'h55555), 64'h400);
    expect_req("R8 vma all", 2'd1, 0, 0, 0, 16'h1234, 20'h55555, 64'h1000);
    accept();
    expect_idle("R1 idle");
  endtask

  task automatic t_vma_single_pa();
    logic [63:0] hi = 64'h0000_0000_0000_07FF;
    send(mk_lo(7'h01, 3'd0, 0, 1, 1, 16'hFFFF, 20'hFFFFF), hi);
    expect_req("R8 vma pscid+addr", 2'd1, 0, 1, 1, 16'hFFFF, 20'hFFFFF, 64'h1000);
    accept();
    expect_idle("R1 idle");
  endtask

  task automatic t_gvma_stall();
    logic [63:0] hi = 64'h3000_0000_0000_4321;
    logic [63:0] snap;
    send(mk_lo(7'h01, 3'd1, 1, 1, 0, 16'hC0DE, 20'h0), hi);
    expect_req("R5 R6 gvma pass1", 2'd2, 1, 0, 1, 16'hC0DE, 20'h0, page(hi));
    snap = {req_tag, req_match_gscid, req_match_pscid, req_match_addr, req_gscid};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(req_valid && req_addr == page(hi) &&
          {req_tag, req_match_gscid, req_match_pscid, req_match_addr, req_gscid} == snap,
          "R2 stall hold", {req_tag, req_match_gscid, req_match_pscid, req_match_addr, req_gscid}, snap);
    end
    accept();
    expect_req("R6 gvma pass2", 2'd3, 1, 0, 1, 16'hC0DE, 20'h0, page(hi));
    accept();
    expect_idle("R6 idle after two passes");
  endtask

  task automatic t_gvma_all();
    send(mk_lo(7'h01, 3'd1, 0, 1, 0, 16'h0F0F, 20'h0), 64'h800);
    expect_req("R5 gvma gv0", 2'd2, 0, 0, 0, 16'h0F0F, 20'h0, 64'h2000);
    accept();
    expect_req("R6 gvma gv0 pass2", 2'd3, 0, 0, 0, 16'h0F0F, 20'h0, 64'h2000);
    accept();
    expect_idle("R6 idle");
  endtask

  task automatic t_gvma_gscid();
    send(mk_lo(7'h01, 3'd1, 1, 0, 0, 16'h00AA, 20'h0), 64'h0);
    expect_req("R5 gvma gscid", 2'd2, 1, 0, 0, 16'h00AA, 20'h0, 64'h0);
    accept();
    expect_req("R6 gvma gscid pass2", 2'd3, 1, 0, 0, 16'h00AA, 20'h0, 64'h0);
    accept();
    expect_idle("R6 idle");
  endtask

  task automatic t_illegal(input string rq, input logic [63:0] lo);
    send(lo, 64'h1234);
    chk(cmd_err && !req_valid && !cmd_ready, rq, {cmd_err, req_valid, cmd_ready}, 3'b100);
    @(negedge clk);
    expect_idle({rq, " recovers"});
  endtask

  initial begin
    #50000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vma_nested_full();
    t_vma_nested_min();
    t_vma_single_all();
    t_vma_single_pa();
    t_gvma_stall();
    t_gvma_all();
    t_gvma_gscid();
    t_illegal("R4 gvma pscv", mk_lo(7'h01, 3'd1, 1, 1, 1, 16'h1111, 20'h22222));
    t_illegal("R9 bad opcode", mk_lo(7'h02, 3'd0, 1, 1, 1, 16'h1111, 20'h22222));
    t_illegal("R9 bad function", mk_lo(7'h01, 3'd3, 0, 0, 0, 16'h0, 20'h0));
    t_vma_single_all();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule